// File: doc/BRIEF.md
# Supply Supervisor Reset and Warning Control

This block is the digital half of a supply-voltage supervisor. Analog comparators outside it report, as already-synchronized flags, whether the supply is below a power-on rearm level, below one of several selectable detect trip levels, or below a warning level. From these flags and a small set of configuration inputs, the block decides when to hold the system in reset. It records why the last reset happened, raises a software-acknowledged warning flag with an optional interrupt request, and tells the power manager when the deepest stop mode must be refused.

A power-on event forces reset regardless of configuration. The reset is then kept asserted until the selected detect comparator reports that the supply has recovered. A low-voltage reset works the same way, but the detector must be active and the reset enable must be set. The detector is active only while it is enabled. While the chip is in a stop mode, it also needs the stop-mode keep bit. Keeping the detector alive across stop mode blocks entry to the deepest stop mode.

Top module: `supply_guard_ctrl`

## Requirements
- R1: When `below_rearm_i` is 1 at a clock edge, `sys_rst_o` is 1 after that edge, whatever the enable inputs are.
- R2: Once `sys_rst_o` is 1, it stays 1 while the selected trip input is 1. It drops after the first edge at which `below_rearm_i` and the selected trip input are both 0. This holds even if the power-on input cleared earlier.
- R3: A power-on event (`below_rearm_i` = 1) sets both `src_por_o` and `src_lv_o` to 1 after the edge.
- R4: With the detector active and `rst_en_i` = 1, a selected trip input of 1 asserts `sys_rst_o` after the edge and loads status por=0, lv=1. With `rst_en_i` = 0 no reset occurs. The held reset ignores later changes of the enables.
- R5: With `det_en_i` = 0, the trip inputs cause no new reset and `below_warn_i` does not set the warning flag.
- R6: With `in_stop_i` = 1 and `stop_keep_i` = 0, the detector is inactive: no new low-voltage reset and no warning. With `stop_keep_i` = 1 it keeps working during stop.
- R7: `deep_stop_block_o` equals `det_en_i & stop_keep_i` as sampled at the previous edge.
- R8: `trip_sel_i` is an index into `below_trip_i`: value 0 selects bit 0 and value 1 selects bit 1. Only the selected bit affects reset.
- R9: With the detector active, `below_warn_i` = 1 sets `warn_flag_o` after the edge. The flag stays set without the input. `warn_irq_o` is 1 exactly when the flag is 1 and `warn_ie_i` was 1 at the same edge.
- R10: `warn_ack_i` = 1 clears the flag at the next edge and has priority over a set. If the warning persists, the flag sets again one edge later.
- R11: Synchronous `rst` clears every output to 0. The reset-source status holds its value until the next power-on or low-voltage reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high register initialization |
| below_rearm_i | input | 1 | Supply below power-on rearm level |
| below_trip_i | input | N_TRIP | Supply below each selectable detect trip level |
| trip_sel_i | input | SEL_W | Index of the trip level in use |
| below_warn_i | input | 1 | Supply below warning level |
| det_en_i | input | 1 | Detector enable |
| stop_keep_i | input | 1 | Keep detector active in stop modes |
| rst_en_i | input | 1 | Low-voltage condition may cause reset |
| warn_ie_i | input | 1 | Warning interrupt enable |
| in_stop_i | input | 1 | Chip is in a stop mode |
| warn_ack_i | input | 1 | Software acknowledge strobe for the warning flag |
| sys_rst_o | output | 1 | System reset request |
| src_por_o | output | 1 | Last reset included a power-on event |
| src_lv_o | output | 1 | Last reset was power-on or low-voltage |
| warn_flag_o | output | 1 | Warning flag |
| warn_irq_o | output | 1 | Warning interrupt request |
| deep_stop_block_o | output | 1 | Deepest stop mode must be refused |

## Verification
The hardest situation to reach is a low-voltage reset that starts with the detector enabled and then outlives the enable. In that case the reset must stay held on the selected comparator alone, after the detector or the reset enable has been turned off. The stimulus fires a reset through one trip index, then clears both enables while the trip input stays low, and only then lets the comparator recover. A second hard case is an acknowledge that arrives while the warning persists. The stimulus holds the warning input high across an acknowledge and checks the clear-then-reset pattern on two consecutive edges.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef struct packed {
    logic por;
    logic lv;
  } rst_src_t;
endpackage

// File: rtl/sg_detect_gate.sv
module sg_detect_gate #(
  parameter int N_TRIP = 2,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              det_en,
  input  logic              stop_keep,
  input  logic              in_stop,
  input  logic [N_TRIP-1:0] trip,
  input  logic [SEL_W-1:0]  sel,
  output logic              det_active,
  output logic              below_det,
  output logic              block_q
);
  localparam logic [SEL_W:0] NTRIP_V = (SEL_W+1)'(N_TRIP);

  // Detector runs when enabled, and during stop only if kept alive.
  assign det_active = det_en & (~in_stop | stop_keep);
  assign below_det  = ({1'b0, sel} < NTRIP_V) ? trip[sel] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) block_q <= 1'b0;
    else     block_q <= det_en & stop_keep;
  end

  a_r7_block_follows: assert property (@(posedge clk) disable iff (rst)
    (det_en && stop_keep) |=> block_q);
  a_r7_block_clear: assert property (@(posedge clk) disable iff (rst)
    !(det_en && stop_keep) |=> !block_q);
endmodule

// File: rtl/sg_reset_hold.sv
module sg_reset_hold
  import sg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     below_rearm,
  input  logic     below_det,
  input  logic     det_active,
  input  logic     rst_en,
  output logic     hold_q,
  output rst_src_t src_q
);
  logic lv_fire;
  logic hold_d;

  assign lv_fire = det_active & rst_en & below_det;
  // Hold release watches the comparator alone, not the enables.
  assign hold_d  = below_rearm | (hold_q & below_det) | lv_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      src_q  <= '0;
    end else begin
      hold_q <= hold_d;
      if (below_rearm)
        src_q <= '{por: 1'b1, lv: 1'b1};
      else if (lv_fire && !hold_q)
        src_q <= '{por: 1'b0, lv: 1'b1};
    end
  end

  a_r1_por_forces_reset: assert property (@(posedge clk) disable iff (rst)
    below_rearm |=> hold_q);
  a_r3_por_status: assert property (@(posedge clk) disable iff (rst)
    below_rearm |=> (src_q.por && src_q.lv));
  a_r2_hold_while_low: assert property (@(posedge clk) disable iff (rst)
    (hold_q && below_det) |=> hold_q);
  a_r2_release: assert property (@(posedge clk) disable iff (rst)
    (!below_rearm && !below_det) |=> !hold_q);
  a_r4_no_reset_when_off: assert property (@(posedge clk) disable iff (rst)
    (!hold_q && !below_rearm && !rst_en) |=> !hold_q);
  a_r11_status_stable: assert property (@(posedge clk) disable iff (rst)
    (!below_rearm && (hold_q || !lv_fire)) |=> $stable(src_q));
endmodule

// File: rtl/sg_warn.sv
module sg_warn (
  input  logic clk,
  input  logic rst,
  input  logic det_active,
  input  logic below_warn,
  input  logic ack,
  input  logic irq_en,
  output logic flag_q,
  output logic irq_q
);
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (ack)                          flag_d = 1'b0;
    else if (det_active && below_warn) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en;
    end
  end

  a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack |=> !flag_q);
  a_r9_warn_sets: assert property (@(posedge clk) disable iff (rst)
    (!ack && det_active && below_warn) |=> flag_q);
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> flag_q);
  a_r5_no_set_inactive: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !det_active) |=> !flag_q);
endmodule

// File: rtl/supply_guard_ctrl.sv
module supply_guard_ctrl
  import sg_pkg::*;
#(
  parameter int  N_TRIP = 2,
  localparam int SEL_W  = (N_TRIP > 1) ? $clog2(N_TRIP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              below_rearm_i,
  input  logic [N_TRIP-1:0] below_trip_i,
  input  logic [SEL_W-1:0]  trip_sel_i,
  input  logic              below_warn_i,
  input  logic              det_en_i,
  input  logic              stop_keep_i,
  input  logic              rst_en_i,
  input  logic              warn_ie_i,
  input  logic              in_stop_i,
  input  logic              warn_ack_i,
  output logic              sys_rst_o,
  output logic              src_por_o,
  output logic              src_lv_o,
  output logic              warn_flag_o,
  output logic              warn_irq_o,
  output logic              deep_stop_block_o
);
  logic     det_active;
  logic     below_det;
  rst_src_t src;

  sg_detect_gate #(.N_TRIP(N_TRIP), .SEL_W(SEL_W)) i_gate (
    .clk        (clk),
    .rst        (rst),
    .det_en     (det_en_i),
    .stop_keep  (stop_keep_i),
    .in_stop    (in_stop_i),
    .trip       (below_trip_i),
    .sel        (trip_sel_i),
    .det_active (det_active),
    .below_det  (below_det),
    .block_q    (deep_stop_block_o)
  );

  sg_reset_hold i_hold (
    .clk         (clk),
    .rst         (rst),
    .below_rearm (below_rearm_i),
    .below_det   (below_det),
    .det_active  (det_active),
    .rst_en      (rst_en_i),
    .hold_q      (sys_rst_o),
    .src_q       (src)
  );

  sg_warn i_warn (
    .clk        (clk),
    .rst        (rst),
    .det_active (det_active),
    .below_warn (below_warn_i),
    .ack        (warn_ack_i),
    .irq_en     (warn_ie_i),
    .flag_q     (warn_flag_o),
    .irq_q      (warn_irq_o)
  );

  assign src_por_o = src.por;
  assign src_lv_o  = src.lv;

  a_r6_stop_gates_reset: assert property (@(posedge clk) disable iff (rst)
    (in_stop_i && !stop_keep_i && !below_rearm_i && !sys_rst_o) |=> !sys_rst_o);
  a_r5_disabled_no_reset: assert property (@(posedge clk) disable iff (rst)
    (!det_en_i && !below_rearm_i && !sys_rst_o) |=> !sys_rst_o);
endmodule

// File: tb/test_supply_guard_ctrl.sv
module test_supply_guard_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       below_rearm_i = 1'b0;
  logic [1:0] below_trip_i = '0;
  logic [0:0] trip_sel_i = '0;
  logic       below_warn_i = 1'b0, det_en_i = 1'b0, stop_keep_i = 1'b0;
  logic       rst_en_i = 1'b0, warn_ie_i = 1'b0, in_stop_i = 1'b0, warn_ack_i = 1'b0;
  logic       sys_rst_o, src_por_o, src_lv_o, warn_flag_o, warn_irq_o, deep_stop_block_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  supply_guard_ctrl #(.N_TRIP(2)) i_supply_guard_ctrl (
    .clk(clk), .rst(rst), .below_rearm_i(below_rearm_i), .below_trip_i(below_trip_i),
    .trip_sel_i(trip_sel_i), .below_warn_i(below_warn_i), .det_en_i(det_en_i),
    .stop_keep_i(stop_keep_i), .rst_en_i(rst_en_i), .warn_ie_i(warn_ie_i),
    .in_stop_i(in_stop_i), .warn_ack_i(warn_ack_i), .sys_rst_o(sys_rst_o),
    .src_por_o(src_por_o), .src_lv_o(src_lv_o), .warn_flag_o(warn_flag_o),
    .warn_irq_o(warn_irq_o), .deep_stop_block_o(deep_stop_block_o)
  );

  // {req, inputs: rearm,trip1,trip0,warn,en,keep,rsten,sel,ie,stop,ack,
  //  expected: rst,por,lv,flag,irq,block}
  localparam int NV = 23;
  localparam logic [20:0] VEC [NV] = '{
    {4'd1,  11'b11100000000, 6'b111000},  // R1 R3 power-on
    {4'd2,  11'b01100000000, 6'b111000},  // R2 held by trip0
    {4'd2,  11'b01000000000, 6'b011000},  // R2 released
    {4'd4,  11'b01001001000, 6'b011000},  // R4 no reset enable
    {4'd8,  11'b01001010000, 6'b011000},  // R8 index 0 not low
    {4'd8,  11'b01001011000, 6'b101000},  // R8 R4 index 1 fires
    {4'd4,  11'b01000001000, 6'b101000},  // R4 held after enables off
    {4'd4,  11'b00000001000, 6'b001000},  // R4 released
    {4'd5,  11'b00100010000, 6'b001000},  // R5 disabled detector
    {4'd6,  11'b00101010010, 6'b001000},  // R6 stop gates detector
    {4'd7,  11'b00101110010, 6'b101001},  // R6 R7 kept in stop
    {4'd7,  11'b00001100000, 6'b001001},  // R7 block stays
    {4'd9,  11'b00011000000, 6'b001100},  // R9 flag, no irq
    {4'd9,  11'b00001000100, 6'b001110},  // R9 flag held, irq
    {4'd10, 11'b00001000101, 6'b001000},  // R10 ack
    {4'd9,  11'b00011000100, 6'b001110},  // R9 set again
    {4'd10, 11'b00011000101, 6'b001000},  // R10 ack beats set
    {4'd10, 11'b00011000100, 6'b001110},  // R10 re-set next edge
    {4'd5,  11'b00010000101, 6'b001000},  // R5 ack while disabled
    {4'd5,  11'b00010000100, 6'b001000},  // R5 no warning disabled
    {4'd6,  11'b00011000110, 6'b001000},  // R6 no warning in stop
    {4'd1,  11'b10000000000, 6'b111000},  // R1 power-on, all off
    {4'd2,  11'b00000000000, 6'b011000}   // R2 release
  };

  task automatic drive(input logic [10:0] v);
    {below_rearm_i, below_trip_i[1], below_trip_i[0], below_warn_i, det_en_i,
     stop_keep_i, rst_en_i, trip_sel_i[0], warn_ie_i, in_stop_i, warn_ack_i} = v;
  endtask

  task automatic chk(input string req, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, name, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [5:0] e);
    chk(req, "sys_rst",  sys_rst_o,         e[5]);
    chk(req, "src_por",  src_por_o,         e[4]);
    chk(req, "src_lv",   src_lv_o,          e[3]);
    chk(req, "flag",     warn_flag_o,       e[2]);
    chk(req, "irq",      warn_irq_o,        e[1]);
    chk(req, "block",    deep_stop_block_o, e[0]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk_all("R11 reset state", 6'b000000);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16:6]);
      @(posedge clk); #1;
      chk_all($sformatf("R%0d vec %0d", VEC[i][20:17], i), VEC[i][5:0]);
    end

    // R11: status persists across idle cycles
    drive(11'b0);
    for (int k = 0; k < 4; k++) begin
      @(posedge clk); #1;
      chk("R11", "src_por idle", src_por_o, 1'b1);
      chk("R11", "src_lv idle",  src_lv_o,  1'b1);
    end

    // R2: long power-on hold on trip0 after rearm clears
    drive(11'b10100000000);
    @(posedge clk); #1;
    drive(11'b00100000000);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk("R2", "sys_rst held", sys_rst_o, 1'b1);
    end
    drive(11'b0);
    @(posedge clk); #1;
    chk("R2", "sys_rst released", sys_rst_o, 1'b0);

    // R11: rst clears everything, including the flag and block
    drive(11'b00011100100);
    @(posedge clk); #1;
    chk("R9", "flag before rst", warn_flag_o, 1'b1);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    drive(11'b0);
    chk_all("R11 mid-run rst", 6'b000000);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule